// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor

This block is a small stored-program processor built around one accumulator. Code and data share one synchronous memory and reach it through one port, so an instruction fetch and an operand access can never overlap. A control state machine walks each instruction through fetch, decode, execute and program-counter update. Every value passes through explicit registers on the way: the program counter, the address latch that drives the memory address, the data latch that captures read data or holds store data, the instruction holding register and the accumulator.

An instruction word is 16 bits wide. The opcode sits in bits 15:12 and a 12-bit memory address sits in bits 11:0. The core runs from address 0 after reset until it decodes a stop opcode. It then raises `halted` and stays idle until the next reset. The memory is expected to return read data one clock after it samples an address with the read strobe high. Writes take effect at the clock edge where the write strobe is high.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter, accumulator and all internal registers clear to zero and the sequencer returns to the start of fetch. Once those edges have passed, `mem_re`, `mem_we` and `halted` are low. The first fetch after reset therefore reads address 0, and a store executed before any load writes 0.
- R2: Cycles are counted from 0 at the start of each instruction. Cycle 0 makes no memory access. Cycle 1 asserts `mem_re` with `mem_addr` equal to the program counter. Cycles 2 to 4 make no access, and decode happens in cycle 4. `mem_re` and `mem_we` are never high together.
- R3: LOAD (opcode 1) asserts a read at the address field in cycle 5 and copies the returned word into the accumulator. The instruction takes 9 cycles in total.
- R4: ADD (opcode 3) reads its operand the same way as LOAD. It adds the operand to the accumulator modulo 2^16, produces no flags, and takes 9 cycles.
- R5: SUB (opcode 4) reads its operand the same way as LOAD. It subtracts the operand from the accumulator modulo 2^16 and takes 9 cycles.
- R6: STORE (opcode 2) asserts `mem_we` in cycle 6. At that moment `mem_addr` equals the address field and `mem_wdata` equals the accumulator. The instruction takes 8 cycles.
- R7: After LOAD, STORE, ADD or SUB, the next fetch address is the old program counter plus one, wrapping at 12 bits. JUMP (opcode 5) takes 5 cycles and makes no operand access. The next fetch reads the address field.
- R8: Opcode 0 and every opcode from 6 to 15 stop the core. From cycle 5 of that instruction, `halted` stays high and neither strobe is asserted until reset.
- R9: Take a core whose program counter is 200 and whose accumulator is 5, with address 1000 holding 7. Executing ADD 1000 leaves 12 in the accumulator, and the next fetch reads address 201.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Shared memory address, driven from the address latch |
| mem_wdata | output | 16 | Store data, driven from the data latch |
| mem_rdata | input | 16 | Read data, valid one cycle after a read strobe |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| halted | output | 1 | High once a stop opcode has been decoded |

## Verification
Instruction fetches and operand accesses compete for the same port, and they can meet in one cycle in two ways. A store can write a word that a later load or subtract reads back through the same port. A jump can redirect the fetch sequence right after an arithmetic result has been formed. The programs chain these orders: a store of the worked-case sum is read back and subtracted from itself, and jumps fall between arithmetic steps. A bench-side instruction model expands every instruction into its expected per-cycle strobes, address and write data, and compares them with the port on every clock. It also checks the final memory contents.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int AW = 12,
  parameter int OW = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [AW-1:0]     mem_addr,
  output logic [OW+AW-1:0]  mem_wdata,
  input  logic [OW+AW-1:0]  mem_rdata,
  output logic              mem_re,
  output logic              mem_we,
  output logic              halted
);
  localparam int DW = OW + AW;
  localparam logic [OW-1:0] OP_LOAD  = OW'(1);
  localparam logic [OW-1:0] OP_STORE = OW'(2);
  localparam logic [OW-1:0] OP_ADD   = OW'(3);
  localparam logic [OW-1:0] OP_SUB   = OW'(4);
  localparam logic [OW-1:0] OP_JUMP  = OW'(5);

  typedef enum logic [3:0] {
    S_FA, S_FW, S_FM, S_FC, S_DEC, S_OW, S_OM, S_EX, S_SM, S_SW, S_UPD, S_HALT
  } state_t;

  state_t        st;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mdr, cir, acc;

  wire [OW-1:0] opc   = cir[DW-1 -: OW];
  wire [AW-1:0] field = cir[AW-1:0];

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_re    = (st == S_FW) || (st == S_OW);
  assign mem_we    = (st == S_SW);
  assign halted    = (st == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_FA;
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      cir <= '0;
      acc <= '0;
    end else begin
      case (st)
        S_FA: begin
          mar <= pc;
          st  <= S_FW;
        end
        S_FW: st <= S_FM;
        S_FM: begin
          mdr <= mem_rdata;
          st  <= S_FC;
        end
        S_FC: begin
          cir <= mdr;
          st  <= S_DEC;
        end
        S_DEC: begin
          case (opc)
            OP_LOAD, OP_ADD, OP_SUB: begin
              mar <= field;
              st  <= S_OW;
            end
            OP_STORE: begin
              mar <= field;
              st  <= S_SM;
            end
            OP_JUMP: begin
              pc <= field;
              st <= S_FA;
            end
            default: st <= S_HALT;
          endcase
        end
        S_OW: st <= S_OM;
        S_OM: begin
          mdr <= mem_rdata;
          st  <= S_EX;
        end
        S_EX: begin
          case (opc)
            OP_ADD:  acc <= acc + mdr;
            OP_SUB:  acc <= acc - mdr;
            default: acc <= mdr;
          endcase
          st <= S_UPD;
        end
        S_SM: begin
          mdr <= acc;
          st  <= S_SW;
        end
        S_SW: st <= S_UPD;
        S_UPD: begin
          pc <= pc + AW'(1);
          st <= S_FA;
        end
        default: st <= S_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_re,
  input logic          mem_we,
  input logic          halted,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] acc,
  input logic [AW-1:0] pc,
  input logic          upd
);
  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_re && !mem_we));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(acc) && $stable(pc)));

  // R6
  store_data_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == acc));

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> (pc == $past(pc) + AW'(1)));

  // R2
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));
endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW), .DW(OW + AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_re    (mem_re),
  .mem_we    (mem_we),
  .halted    (halted),
  .mem_wdata (mem_wdata),
  .acc       (acc),
  .pc        (pc),
  .upd       (st == S_UPD)
);

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_re, mem_we, halted;

  int vectors = 0;
  int misses  = 0;

  always #4 clk = ~clk;

  acc_cpu dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_re(mem_re), .mem_we(mem_we), .halted(halted)
  );

  logic [15:0] mem     [0:4095];
  logic [15:0] ref_mem [0:4095];

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  typedef struct {
    bit          re;
    bit          we;
    bit          h;
    logic [11:0] addr;
    logic [15:0] wd;
    string       tag;
  } cyc_t;

  cyc_t exp_q[$];

  function automatic void push(bit re, bit we, bit h, logic [11:0] a, logic [15:0] wd, string tag);
    cyc_t c;
    c.re = re; c.we = we; c.h = h; c.addr = a; c.wd = wd; c.tag = tag;
    exp_q.push_back(c);
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) begin
      mem[i] = '0;
      ref_mem[i] = '0;
    end
  endtask

  task automatic put(int a, logic [15:0] v);
    mem[a] = v;
    ref_mem[a] = v;
  endtask

  task automatic build();
    logic [11:0] pc = '0;
    logic [15:0] acc = '0;
    exp_q.delete();
    for (int n = 0; n < 500; n++) begin
      logic [15:0] w = ref_mem[pc];
      logic [3:0]  op = w[15:12];
      logic [11:0] a = w[11:0];
      push(0, 0, 0, 0, 0, "R2");
      push(1, 0, 0, pc, 0, (n == 0) ? "R1" : "R7");
      for (int k = 0; k < 3; k++) push(0, 0, 0, 0, 0, "R2");
      if (op == 4'd1 || op == 4'd3 || op == 4'd4) begin
        push(1, 0, 0, a, 0, op == 4'd1 ? "R3" : (op == 4'd3 ? "R4" : "R5"));
        for (int k = 0; k < 3; k++) push(0, 0, 0, 0, 0, "R3");
        if (op == 4'd1) acc = ref_mem[a];
        else if (op == 4'd3) acc = acc + ref_mem[a];
        else acc = acc - ref_mem[a];
        pc = pc + 12'd1;
      end else if (op == 4'd2) begin
        push(0, 0, 0, 0, 0, "R6");
        push(0, 1, 0, a, acc, "R6");
        push(0, 0, 0, 0, 0, "R6");
        ref_mem[a] = acc;
        pc = pc + 12'd1;
      end else if (op == 4'd5) begin
        pc = a;
      end else begin
        for (int k = 0; k < 12; k++) push(0, 0, 1, 0, 0, "R8");
        break;
      end
    end
  endtask

  task automatic check(bit ok, string tag, string what, int got, int expv);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, expv);
    end
  endtask

  task automatic run_prog();
    build();
    rst = 1'b1;
    @(posedge clk);
    repeat (2) begin
      @(negedge clk);
      #1;
      check(!mem_re && !mem_we && !halted, "R1", "strobes/halt in reset",
            {mem_re, mem_we, halted}, 0);
    end
    @(negedge clk);
    rst = 1'b0;
    while (exp_q.size() > 0) begin
      cyc_t c = exp_q.pop_front();
      #1;
      vectors++;
      if (mem_re !== c.re || mem_we !== c.we || halted !== c.h ||
          ((c.re || c.we) && mem_addr !== c.addr) || (c.we && mem_wdata !== c.wd)) begin
        misses++;
        $display("FAIL %s cycle: got re=%b we=%b h=%b addr=%0d wd=%0h expected re=%b we=%b h=%b addr=%0d wd=%0h",
                 c.tag, mem_re, mem_we, halted, mem_addr, mem_wdata,
                 c.re, c.we, c.h, c.addr, c.wd);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    misses++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    // Program A: reset zero store, worked case, wrap, read-back of stored word
    clear_mem();
    put(0,   16'h21F4);
    put(1,   16'h13E9);
    put(2,   16'h50C8);
    put(200, 16'h33E8);
    put(201, 16'h23EA);
    put(202, 16'h13EB);
    put(203, 16'h33EC);
    put(204, 16'h23ED);
    put(205, 16'h43EE);
    put(206, 16'h23EF);
    put(207, 16'h13EA);
    put(208, 16'h43EA);
    put(209, 16'h23F0);
    put(210, 16'h0000);
    put(1000, 16'd7);
    put(1001, 16'd5);
    put(1003, 16'hFFFF);
    put(1004, 16'h0003);
    put(1006, 16'h0005);
    mem[500] = 16'hAAAA;
    ref_mem[500] = 16'hAAAA;
    run_prog();
    check(mem[500] == 16'h0000, "R1", "mem[500]", mem[500], 0);
    check(mem[1002] == 16'd12, "R9", "mem[1002]", mem[1002], 12);
    check(mem[1005] == 16'h0002, "R4", "mem[1005]", mem[1005], 2);
    check(mem[1007] == 16'hFFFD, "R5", "mem[1007]", mem[1007], 16'hFFFD);
    check(mem[1008] == 16'h0000, "R5", "mem[1008]", mem[1008], 0);

    // Program B: jump to top address, undefined opcode stops the core
    clear_mem();
    put(0,    16'h100A);
    put(1,    16'h5FFF);
    put(4095, 16'hF123);
    put(10,   16'h1234);
    put(291,  16'h5555);
    run_prog();
    check(mem[291] == 16'h5555, "R8", "mem[291] untouched", mem[291], 16'h5555);
    check(halted == 1'b1, "R8", "halted held", halted, 1);

    // Program C: reset leaves halt, opcode 9 stops at once
    clear_mem();
    put(0, 16'h9000);
    run_prog();
    check(halted == 1'b1, "R8", "halted after opcode 9", halted, 1);

    // Program D: store then load back, then jump loop exit via opcode 0
    clear_mem();
    put(0, 16'h1064);
    put(1, 16'h2065);
    put(2, 16'h3065);
    put(3, 16'h2066);
    put(4, 16'h5006);
    put(5, 16'h2067);
    put(6, 16'h0ABC);
    put(100, 16'h8001);
    run_prog();
    check(mem[101] == 16'h8001, "R6", "mem[101]", mem[101], 16'h8001);
    check(mem[102] == 16'h0002, "R4", "mem[102]", mem[102], 2);
    check(mem[103] == 16'h0000, "R7", "mem[103] skipped", mem[103], 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule